// File: doc/BRIEF.md
# Deadline-Capable Local Interrupt Timer

A per-core timer that raises an interrupt request carrying a programmable 8-bit vector. It runs in one of three modes, picked by a 2-bit field of its control word. In one-shot mode it counts down once from a loaded value. In periodic mode it counts down and reloads. In deadline mode it compares an absolute 64-bit target against a free-running timestamp input. Software reaches the control word and the two count registers over a small register bus with a 2-bit address. The 64-bit target has a port of its own.

The two timing schemes share the interrupt output, and they lock each other out. Any write that changes the mode field wipes all timer state. The count registers read as zero and ignore writes while deadline mode is active. The target register reads as zero and ignores writes in the other modes.

Two state machines carry the behaviour:
- The countdown machine has states `CD_IDLE` and `CD_RUN`. A nonzero initial-count write takes it from `CD_IDLE` to `CD_RUN`. Expiry in one-shot mode takes it back to `CD_IDLE`. Expiry in periodic mode keeps it in `CD_RUN` and reloads the count. A zero initial-count write or a mode change takes it from `CD_RUN` to `CD_IDLE`.
- The deadline machine has states `DL_IDLE` and `DL_ARMED`. A write of a target above the timestamp takes it from `DL_IDLE` to `DL_ARMED`. Expiry, a zero write, a write of a past target, or a mode change takes it from `DL_ARMED` to `DL_IDLE`.

Top module: `dl_irq_timer`

## Requirements
- R1: The control word holds these fields:
  - the vector in bits 7:0;
  - the mask in bit 16;
  - the mode in bits 18:17, with 00 one-shot, 01 periodic, 10 deadline, and 11 acting as one-shot.

  Reading it at address 0 returns these fields and zeros elsewhere. The initial count is at address 1, and the current count is read-only at address 2.
- R2: A control write whose mode field differs from the stored mode clears the initial count, the current count and the deadline target to zero, and cancels any pending expiry.
- R3: In deadline mode, addresses 1 and 2 read 0 and writes to address 1 are ignored.
- R4: Outside deadline mode, the deadline port reads 0 and writes to it are ignored.
- R5: In deadline mode, writing target 0 disarms the timer and raises no interrupt.
- R6: In deadline mode, writing a nonzero target that is at or below the timestamp stores 0 and raises the interrupt in the cycle after the write edge.
- R7: In deadline mode, writing a target above the timestamp stores and arms it. On the first edge where the timestamp is at or above the target, the interrupt is raised once and the target clears to 0. The timer does not rearm.
- R8: When a deadline write and a pending compare fall on the same edge, the written value decides the outcome and the old target is dropped.
- R9: In one-shot mode, writing N>0 to the initial count loads the current count with N. The count decrements once per cycle, raises the interrupt on the N-th edge after the write, and then stays at 0.
- R10: In periodic mode, the current count reloads from the initial count on expiry, so the interrupt repeats every N cycles.
- R11: Writing 0 to the initial count stops the countdown with no interrupt.
- R12: The interrupt is a one-cycle registered pulse with the vector on `irq_vector`. When the mask bit is set the pulse is suppressed, but the count and target state update as if it had fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register bus write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 initial count, 2 current count |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| dl_wr_en | input | 1 | Deadline target write strobe |
| dl_wdata | input | TS_W | Deadline target write data |
| dl_rdata | output | TS_W | Deadline target read value |
| tsc | input | TS_W | Free-running timestamp |
| irq_valid | output | 1 | Interrupt request pulse |
| irq_vector | output | 8 | Vector carried with the pulse |

## Verification
The checker holds several invariants on every cycle:
- a mode change leaves all timer state at zero;
- the counts stay zero in deadline mode;
- the target reads zero outside it;
- the current count never exceeds the initial count;
- no pulse follows a masked cycle;
- every pulse leaves the target at zero.

Exact expiry cycles for one-shot and periodic counts need the bench's directed scenarios. So do the write-over-compare race, past and equal targets, ignored writes, and the masked timer running on in the background.

// File: rtl/dlt_pkg.sv
`timescale 1ns/1ps
package dlt_pkg;
    localparam int VEC_W        = 8;
    localparam int CTL_MASK_BIT = 16;
    localparam int CTL_MODE_LO  = 17;
    localparam int CTL_MODE_HI  = CTL_MODE_LO + 1;

    localparam logic [1:0] ADDR_CTL  = 2'd0;
    localparam logic [1:0] ADDR_INIT = 2'd1;
    localparam logic [1:0] ADDR_CUR  = 2'd2;

    typedef enum logic [1:0] {
        MODE_ONESHOT  = 2'b00,
        MODE_PERIODIC = 2'b01,
        MODE_DEADLINE = 2'b10,
        MODE_RSVD     = 2'b11
    } tmode_e;

    typedef enum logic {
        CD_IDLE = 1'b0,
        CD_RUN  = 1'b1
    } cd_state_e;

    typedef enum logic {
        DL_IDLE  = 1'b0,
        DL_ARMED = 1'b1
    } dl_state_e;
endpackage

// File: rtl/dlt_ctl_regs.sv
`timescale 1ns/1ps
module dlt_ctl_regs
    import dlt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VEC_W-1:0] wr_vec,
    input  logic             wr_mask,
    input  tmode_e           wr_mode,
    output logic [VEC_W-1:0] vec_q,
    output logic             mask_q,
    output tmode_e           mode_q,
    output logic             mode_chg
);
    // Mode change strobe: shared clear for both timing engines
    always_comb begin
        mode_chg = wr_en && (wr_mode != mode_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q  <= '0;
            mask_q <= 1'b0;
            mode_q <= MODE_ONESHOT;
        end else if (wr_en) begin
            vec_q  <= wr_vec;
            mask_q <= wr_mask;
            mode_q <= wr_mode;
        end
    end
endmodule

// File: rtl/dlt_countdown.sv
`timescale 1ns/1ps
module dlt_countdown
    import dlt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             periodic,
    input  logic             init_wr,
    input  logic [CNT_W-1:0] init_wdata,
    output logic [CNT_W-1:0] init_q,
    output logic [CNT_W-1:0] cur_q,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cd_state_e        state_q, state_n;
    logic [CNT_W-1:0] init_n, cur_n;
    logic             load;

    assign load = init_wr && enable;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CD_IDLE;
            init_q  <= '0;
            cur_q   <= '0;
        end else begin
            state_q <= state_n;
            init_q  <= init_n;
            cur_q   <= cur_n;
        end
    end

    // Next state: clear beats load, load beats expiry
    always_comb begin
        state_n = state_q;
        init_n  = init_q;
        cur_n   = cur_q;
        if (clear) begin
            state_n = CD_IDLE;
            init_n  = '0;
            cur_n   = '0;
        end else if (load) begin
            init_n  = init_wdata;
            cur_n   = init_wdata;
            state_n = (init_wdata == '0) ? CD_IDLE : CD_RUN;
        end else begin
            unique case (state_q)
                CD_IDLE: begin
                    cur_n = cur_q;
                end
                CD_RUN: begin
                    if (cur_q == ONE) begin
                        if (periodic) begin
                            cur_n = init_q;
                        end else begin
                            cur_n   = '0;
                            state_n = CD_IDLE;
                        end
                    end else begin
                        cur_n = cur_q - ONE;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            CD_IDLE: fire = 1'b0;
            CD_RUN:  fire = !clear && !load && (cur_q == ONE);
        endcase
    end
endmodule

// File: rtl/dlt_deadline.sv
`timescale 1ns/1ps
module dlt_deadline
    import dlt_pkg::*;
#(
    parameter int TS_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            enable,
    input  logic            wr,
    input  logic [TS_W-1:0] wdata,
    input  logic [TS_W-1:0] tsc,
    output logic [TS_W-1:0] dl_q,
    output logic            fire
);
    dl_state_e       state_q, state_n;
    logic [TS_W-1:0] dl_n;
    logic            take;
    logic            past_wr;

    assign take    = wr && enable;
    assign past_wr = (wdata != '0) && (wdata <= tsc);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DL_IDLE;
            dl_q    <= '0;
        end else begin
            state_q <= state_n;
            dl_q    <= dl_n;
        end
    end

    // Next state: clear beats write, write beats compare
    always_comb begin
        state_n = state_q;
        dl_n    = dl_q;
        if (clear) begin
            state_n = DL_IDLE;
            dl_n    = '0;
        end else if (take) begin
            if (wdata == '0 || past_wr) begin
                state_n = DL_IDLE;
                dl_n    = '0;
            end else begin
                state_n = DL_ARMED;
                dl_n    = wdata;
            end
        end else begin
            unique case (state_q)
                DL_IDLE: dl_n = dl_q;
                DL_ARMED: begin
                    if (tsc >= dl_q) begin
                        state_n = DL_IDLE;
                        dl_n    = '0;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        fire = 1'b0;
        if (!clear) begin
            if (take) begin
                fire = past_wr;
            end else begin
                unique case (state_q)
                    DL_IDLE:  fire = 1'b0;
                    DL_ARMED: fire = (tsc >= dl_q);
                endcase
            end
        end
    end
endmodule

// File: rtl/dl_irq_timer.sv
`timescale 1ns/1ps
module dl_irq_timer
    import dlt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int TS_W   = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dl_wr_en,
    input  logic [TS_W-1:0]   dl_wdata,
    output logic [TS_W-1:0]   dl_rdata,
    input  logic [TS_W-1:0]   tsc,
    output logic              irq_valid,
    output logic [VEC_W-1:0]  irq_vector
);
    logic [VEC_W-1:0] ctl_vec;
    logic             ctl_mask;
    tmode_e           ctl_mode;
    logic             mode_chg;
    logic             dl_mode;
    logic [CNT_W-1:0] init_q, cur_q;
    logic [TS_W-1:0]  dl_q;
    logic             cd_fire, dl_fire, any_fire;
    logic [DATA_W-1:0] ctl_rd;

    dlt_ctl_regs u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en && (reg_addr == ADDR_CTL)),
        .wr_vec   (reg_wdata[VEC_W-1:0]),
        .wr_mask  (reg_wdata[CTL_MASK_BIT]),
        .wr_mode  (tmode_e'(reg_wdata[CTL_MODE_HI:CTL_MODE_LO])),
        .vec_q    (ctl_vec),
        .mask_q   (ctl_mask),
        .mode_q   (ctl_mode),
        .mode_chg (mode_chg)
    );

    assign dl_mode = (ctl_mode == MODE_DEADLINE);

    dlt_countdown #(.CNT_W(CNT_W)) u_cd (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (mode_chg),
        .enable     (!dl_mode),
        .periodic   (ctl_mode == MODE_PERIODIC),
        .init_wr    (reg_wr_en && (reg_addr == ADDR_INIT)),
        .init_wdata (reg_wdata[CNT_W-1:0]),
        .init_q     (init_q),
        .cur_q      (cur_q),
        .fire       (cd_fire)
    );

    dlt_deadline #(.TS_W(TS_W)) u_dl (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (mode_chg),
        .enable(dl_mode),
        .wr    (dl_wr_en),
        .wdata (dl_wdata),
        .tsc   (tsc),
        .dl_q  (dl_q),
        .fire  (dl_fire)
    );

    assign any_fire = cd_fire || dl_fire;

    // Control word readback
    always_comb begin
        ctl_rd = '0;
        ctl_rd[VEC_W-1:0] = ctl_vec;
        ctl_rd[CTL_MASK_BIT] = ctl_mask;
        ctl_rd[CTL_MODE_HI:CTL_MODE_LO] = ctl_mode;
    end

    // Register read mux with mode-dependent hiding
    always_comb begin
        unique case (reg_addr)
            ADDR_CTL:  reg_rdata = ctl_rd;
            ADDR_INIT: reg_rdata = dl_mode ? '0 : DATA_W'(init_q);
            ADDR_CUR:  reg_rdata = dl_mode ? '0 : DATA_W'(cur_q);
            default:   reg_rdata = '0;
        endcase
    end

    assign dl_rdata = dl_mode ? dl_q : '0;

    // Registered interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid  <= 1'b0;
            irq_vector <= '0;
        end else begin
            irq_valid  <= any_fire && !ctl_mask;
            irq_vector <= (any_fire && !ctl_mask) ? ctl_vec : '0;
        end
    end
endmodule

// File: rtl/dl_irq_timer_chk.sv
`timescale 1ns/1ps
module dl_irq_timer_chk #(
    parameter int CNT_W = 32,
    parameter int TS_W  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             mask,
    input logic [CNT_W-1:0] init_q,
    input logic [CNT_W-1:0] cur_q,
    input logic [TS_W-1:0]  dl_q,
    input logic [TS_W-1:0]  dl_rdata,
    input logic             irq_valid
);
    p_mode_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> (init_q == '0 && cur_q == '0 && dl_q == '0));

    p_cnt_hidden_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |-> (init_q == '0 && cur_q == '0));

    p_dl_hidden_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 2'b10) |-> (dl_rdata == '0));

    p_fire_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> (dl_q == '0));

    p_cur_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q <= init_q);

    p_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(mask));
endmodule

bind dl_irq_timer dl_irq_timer_chk #(.CNT_W(CNT_W), .TS_W(TS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (ctl_mode),
    .mask      (ctl_mask),
    .init_q    (init_q),
    .cur_q     (cur_q),
    .dl_q      (dl_q),
    .dl_rdata  (dl_rdata),
    .irq_valid (irq_valid)
);

// File: tb/dl_irq_timer_bench.sv
`timescale 1ns/1ps
module dl_irq_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dl_wr_en = 1'b0;
    logic [63:0] dl_wdata = '0;
    logic [63:0] dl_rdata;
    logic [63:0] tsc = 64'd1000;
    logic        irq_valid;
    logic [7:0]  irq_vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dl_irq_timer u_dl_irq_timer (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dl_wr_en(dl_wr_en), .dl_wdata(dl_wdata), .dl_rdata(dl_rdata),
        .tsc(tsc), .irq_valid(irq_valid), .irq_vector(irq_vector)
    );

    function automatic logic [31:0] ctlw(input logic [7:0] vec, input logic msk, input logic [1:0] md);
        return {13'd0, md, msk, 8'd0, vec};
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic dl_wr(input logic [63:0] d);
        @(negedge clk);
        dl_wr_en = 1'b1; dl_wdata = d;
        @(negedge clk);
        dl_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic quiet(input string req, input int n);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (irq_valid) hits++;
        end
        chk(req, "no interrupt in window", 64'(hits), 64'd0);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); chk("R1", "reset control", 64'(d), 64'd0);
        rd(2'd1, d); chk("R1", "reset init", 64'(d), 64'd0);
        rd(2'd2, d); chk("R1", "reset cur", 64'(d), 64'd0);
        chk("R12", "reset irq", 64'(irq_valid), 64'd0);
        chk("R4", "reset deadline read", dl_rdata, 64'd0);
    endtask

    task automatic t_ctl_fields;
        logic [31:0] d;
        bus_wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); chk("R1", "control readback", 64'(d), 64'h0007_00FF);
        bus_wr(2'd0, ctlw(8'h7E, 1'b0, 2'b11));
        bus_wr(2'd1, 32'd2);
        @(negedge clk); chk("R1", "mode 11 not yet", 64'(irq_valid), 64'd0);
        @(negedge clk); chk("R1", "mode 11 fires as one-shot", 64'(irq_valid), 64'd1);
        chk("R1", "mode 11 vector", 64'(irq_vector), 64'h7E);
        quiet("R1", 6);
    endtask

    task automatic t_oneshot;
        logic [31:0] d;
        bus_wr(2'd0, ctlw(8'h41, 1'b0, 2'b00));
        bus_wr(2'd1, 32'd5);
        rd(2'd2, d); chk("R9", "cur loaded", 64'(d), 64'd5);
        for (int i = 1; i <= 5; i++) begin
            @(negedge clk);
            chk("R9", $sformatf("one-shot irq cycle %0d", i), 64'(irq_valid), (i == 5) ? 64'd1 : 64'd0);
            if (i == 5) chk("R12", "one-shot vector", 64'(irq_vector), 64'h41);
        end
        @(negedge clk); chk("R12", "pulse one cycle", 64'(irq_valid), 64'd0);
        rd(2'd2, d); chk("R9", "cur stays zero", 64'(d), 64'd0);
        quiet("R9", 10);
    endtask

    task automatic t_periodic;
        logic [31:0] d;
        bus_wr(2'd0, ctlw(8'h52, 1'b0, 2'b01));
        bus_wr(2'd1, 32'd3);
        for (int i = 1; i <= 9; i++) begin
            @(negedge clk);
            chk("R10", $sformatf("periodic irq cycle %0d", i), 64'(irq_valid), (i % 3 == 0) ? 64'd1 : 64'd0);
        end
        bus_wr(2'd1, 32'd0);
        quiet("R11", 8);
        rd(2'd2, d); chk("R11", "cur after stop", 64'(d), 64'd0);
    endtask

    task automatic t_mask;
        logic [31:0] d;
        int hits = 0;
        bus_wr(2'd0, ctlw(8'h52, 1'b1, 2'b01));
        bus_wr(2'd1, 32'd2);
        @(negedge clk); rd(2'd2, d); chk("R12", "masked cur 1", 64'(d), 64'd1);
        chk("R12", "masked no irq", 64'(irq_valid), 64'd0);
        @(negedge clk); rd(2'd2, d); chk("R12", "masked reload", 64'(d), 64'd2);
        chk("R12", "masked no irq at expiry", 64'(irq_valid), 64'd0);
        quiet("R12", 4);
        bus_wr(2'd0, ctlw(8'h52, 1'b0, 2'b01));
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (irq_valid) hits++;
        end
        chk("R12", "unmasked timer kept running", 64'(hits), 64'd2);
    endtask

    task automatic t_mode_switch;
        logic [31:0] d;
        bus_wr(2'd0, ctlw(8'h63, 1'b0, 2'b10));
        chk("R2", "deadline cleared on switch", dl_rdata, 64'd0);
        rd(2'd1, d); chk("R3", "init hidden", 64'(d), 64'd0);
        rd(2'd2, d); chk("R3", "cur hidden", 64'(d), 64'd0);
        bus_wr(2'd1, 32'd7);
        rd(2'd1, d); chk("R3", "init write ignored read", 64'(d), 64'd0);
        quiet("R3", 10);
    endtask

    task automatic t_dl_arm;
        @(negedge clk); tsc = 64'd1000;
        dl_wr(64'd1005);
        chk("R7", "target stored", dl_rdata, 64'd1005);
        chk("R7", "no irq on arm", 64'(irq_valid), 64'd0);
        tsc = 64'd1004;
        @(negedge clk); chk("R7", "below target", 64'(irq_valid), 64'd0);
        tsc = 64'd1005;
        @(negedge clk); chk("R7", "fires at target", 64'(irq_valid), 64'd1);
        chk("R7", "deadline vector", 64'(irq_vector), 64'h63);
        chk("R7", "target cleared", dl_rdata, 64'd0);
        @(negedge clk); chk("R7", "pulse once", 64'(irq_valid), 64'd0);
        tsc = 64'd2000;
        quiet("R7", 5);
    endtask

    task automatic t_dl_past;
        dl_wr(64'd1500);
        chk("R6", "past fires", 64'(irq_valid), 64'd1);
        chk("R6", "past stores zero", dl_rdata, 64'd0);
        @(negedge clk); chk("R6", "past pulse ends", 64'(irq_valid), 64'd0);
        dl_wr(64'd2000);
        chk("R6", "equal fires", 64'(irq_valid), 64'd1);
        chk("R6", "equal stores zero", dl_rdata, 64'd0);
    endtask

    task automatic t_dl_zero;
        dl_wr(64'd2500);
        chk("R5", "armed", dl_rdata, 64'd2500);
        dl_wr(64'd0);
        chk("R5", "zero write disarm", dl_rdata, 64'd0);
        @(negedge clk); tsc = 64'd3000;
        quiet("R5", 5);
    endtask

    task automatic t_dl_race;
        dl_wr(64'd3100);
        @(negedge clk);
        tsc = 64'd3100; dl_wr_en = 1'b1; dl_wdata = 64'd3500;
        @(negedge clk);
        dl_wr_en = 1'b0;
        chk("R8", "write beats compare irq", 64'(irq_valid), 64'd0);
        chk("R8", "write beats compare value", dl_rdata, 64'd3500);
        @(negedge clk); chk("R8", "still armed", 64'(irq_valid), 64'd0);
        tsc = 64'd3500;
        @(negedge clk); chk("R8", "new target fires", 64'(irq_valid), 64'd1);
    endtask

    task automatic t_dl_cancel;
        logic [31:0] d;
        dl_wr(64'd4000);
        chk("R2", "armed before switch", dl_rdata, 64'd4000);
        bus_wr(2'd0, ctlw(8'h63, 1'b0, 2'b01));
        chk("R2", "target hidden after switch", dl_rdata, 64'd0);
        @(negedge clk); tsc = 64'd5000;
        quiet("R2", 5);
        rd(2'd2, d); chk("R2", "cur zero after switch", 64'(d), 64'd0);
    endtask

    task automatic t_dl_outside;
        dl_wr(64'd100);
        chk("R4", "outside write no irq", 64'(irq_valid), 64'd0);
        chk("R4", "outside read zero", dl_rdata, 64'd0);
        quiet("R4", 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctl_fields();
        t_oneshot();
        t_periodic();
        t_mask();
        t_mode_switch();
        t_dl_arm();
        t_dl_past();
        t_dl_zero();
        t_dl_race();
        t_dl_cancel();
        t_dl_outside();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule